// File: doc/BRIEF.md
# FIFO Threshold Interrupt Generator

This block watches the fill counts of a transmit FIFO and a receive FIFO, each 64 entries deep. From those counts it raises three interrupt conditions. Transmit-ready means enough free slots exist to accept a burst. Receive-ready means enough characters have arrived to be worth draining. Receive-timeout means characters are waiting and the line has gone quiet. The block also drives the two level values that software reads: free transmit slots and stored receive characters.

Each threshold comes from one 4-bit field of an 8-bit threshold register. The field is multiplied by four, which gives 4 to 60. When the field is zero, or when the extended threshold register is switched off, a fixed table indexed by a 2-bit legacy selection provides the threshold instead. The transmit threshold is compared against free space, not against occupancy. The timeout condition is registered: a one-cycle idle pulse from an external character timer sets it, and reading the receive FIFO clears it.

Top module: `fifo_trig_irq`

## Requirements
- R1: With `ext_trig_en`=1 and `trig_cfg[3:0]`=N≠0, the transmit threshold is 4·N.
- R2: With `ext_trig_en`=1 and `trig_cfg[7:4]`=N≠0, the receive threshold is 4·N.
- R3: When the transmit threshold comes from the legacy table, `tx_legacy_sel` codes 0,1,2,3 give 8,16,32,56.
- R4: When the receive threshold comes from the legacy table, `rx_legacy_sel` codes 0,1,2,3 give 8,16,56,60.
- R5: With `ext_trig_en`=0, both thresholds come from the legacy table, whatever `trig_cfg` holds. With `ext_trig_en`=1, a zero field also selects the legacy table.
- R6: `tx_ready_irq` is high in the same cycle that `tx_space` is greater than or equal to the transmit threshold, and low otherwise.
- R7: `rx_ready_irq` is high in the same cycle that `rx_count` is greater than or equal to the receive threshold, and low otherwise.
- R8: `rx_idle_pulse` with `rx_count`≥1 and no `rx_pop` sets `rx_timeout_irq` at the next clock edge, whatever the receive threshold. The flag then holds until it is cleared.
- R9: `rx_idle_pulse` while `rx_count`=0 leaves `rx_timeout_irq` low.
- R10: `rx_pop` or `rx_count`=0 clears `rx_timeout_irq` at the next clock edge. A clear wins over an idle pulse in the same cycle.
- R11: `tx_space` equals 64 − `tx_count` (64 when the FIFO is empty, 0 when full), and `rx_avail` equals `rx_count`.
- R12: While reset is active, and after its release, `rx_timeout_irq` is 0 until it is first set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_count | input | 7 | Entries held in the transmit FIFO (0..64) |
| rx_count | input | 7 | Entries held in the receive FIFO (0..64) |
| trig_cfg | input | 8 | Threshold register: [3:0] transmit field, [7:4] receive field |
| tx_legacy_sel | input | 2 | Legacy transmit threshold code |
| rx_legacy_sel | input | 2 | Legacy receive threshold code |
| ext_trig_en | input | 1 | Enables use of the threshold register fields |
| rx_idle_pulse | input | 1 | One-cycle pulse: the receive line has been idle for the timeout period |
| rx_pop | input | 1 | The receive FIFO is read in this cycle |
| tx_ready_irq | output | 1 | Free transmit space at or above the threshold |
| rx_ready_irq | output | 1 | Receive fill at or above the threshold |
| rx_timeout_irq | output | 1 | Receive timeout pending |
| tx_space | output | 7 | Free transmit slots |
| rx_avail | output | 7 | Stored receive characters |

## Verification
The bench sweeps every field value and every legacy code, with the extended enable both on and off. For each it places the counts exactly one below and exactly at the threshold. A design that compared transmit occupancy instead of free space, used a strict comparison, or let a zero field produce a threshold of zero would be caught at those edges. The timeout scenarios cover an idle pulse into an empty FIFO, an idle pulse coinciding with a read, and a FIFO that drains without being read. A design that gave the set priority over the clear, or that gated the timeout on the receive threshold, would show a stale flag in those cases.

// File: rtl/fti_pkg.sv
package fti_pkg;
  localparam int FTI_DEPTH = 64;
  localparam int FTI_CW    = $clog2(FTI_DEPTH + 1);
  localparam int FTI_SCALE = 4;

  typedef logic [FTI_CW-1:0] fti_cnt_t;

  // legacy threshold tables, index = 2-bit code
  function automatic fti_cnt_t fti_tx_legacy(input logic [1:0] code);
    case (code)
      2'd0:    return fti_cnt_t'(8);
      2'd1:    return fti_cnt_t'(16);
      2'd2:    return fti_cnt_t'(32);
      default: return fti_cnt_t'(56);
    endcase
  endfunction

  function automatic fti_cnt_t fti_rx_legacy(input logic [1:0] code);
    case (code)
      2'd0:    return fti_cnt_t'(8);
      2'd1:    return fti_cnt_t'(16);
      2'd2:    return fti_cnt_t'(56);
      default: return fti_cnt_t'(60);
    endcase
  endfunction
endpackage

// File: rtl/fti_rst_sync.sv
module fti_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fti_thresh_sel.sv
module fti_thresh_sel
  import fti_pkg::*;
#(
  parameter bit IS_RX = 1'b0,
  parameter int FW    = 4,
  parameter int CW    = FTI_CW,
  parameter int SCALE = FTI_SCALE
) (
  input  logic [FW-1:0] field,
  input  logic [1:0]    legacy_sel,
  input  logic          ext_en,
  output logic [CW-1:0] level
);
  localparam int SHIFT = $clog2(SCALE);

  logic [CW-1:0] legacy_lvl;
  logic [CW-1:0] scaled_lvl;
  logic          use_field;

  generate
    if (IS_RX) begin : g_rx_tab
      assign legacy_lvl = CW'(fti_rx_legacy(legacy_sel));
    end else begin : g_tx_tab
      assign legacy_lvl = CW'(fti_tx_legacy(legacy_sel));
    end
  endgenerate

  assign scaled_lvl = CW'({field, {SHIFT{1'b0}}});
  assign use_field  = ext_en && (field != '0);

  always_comb begin
    if (use_field) level = scaled_lvl;
    else           level = legacy_lvl;
  end
endmodule

// File: rtl/fti_rx_timeout.sv
module fti_rx_timeout #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_count,
  input  logic          idle_pulse,
  input  logic          pop,
  output logic          timeout
);
  logic timeout_q;
  logic timeout_d;
  logic timeout_en;

  always_comb begin
    timeout_d  = timeout_q;
    timeout_en = 1'b0;
    if (pop || (rx_count == '0)) begin
      timeout_d  = 1'b0;
      timeout_en = 1'b1;
    end else if (idle_pulse) begin
      timeout_d  = 1'b1;
      timeout_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          timeout_q <= 1'b0;
    else if (timeout_en) timeout_q <= timeout_d;
  end

  assign timeout = timeout_q;
endmodule

// File: rtl/fifo_trig_irq.sv
module fifo_trig_irq
  import fti_pkg::*;
#(
  parameter int DEPTH = FTI_DEPTH,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic [7:0]    trig_cfg,
  input  logic [1:0]    tx_legacy_sel,
  input  logic [1:0]    rx_legacy_sel,
  input  logic          ext_trig_en,
  input  logic          rx_idle_pulse,
  input  logic          rx_pop,
  output logic          tx_ready_irq,
  output logic          rx_ready_irq,
  output logic          rx_timeout_irq,
  output logic [CW-1:0] tx_space,
  output logic [CW-1:0] rx_avail
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          rst_sync_n;
  logic [CW-1:0] tx_level;
  logic [CW-1:0] rx_level;

  fti_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  fti_thresh_sel #(.IS_RX(1'b0), .FW(4), .CW(CW)) u_tx_sel (
    .field     (trig_cfg[3:0]),
    .legacy_sel(tx_legacy_sel),
    .ext_en    (ext_trig_en),
    .level     (tx_level)
  );

  fti_thresh_sel #(.IS_RX(1'b1), .FW(4), .CW(CW)) u_rx_sel (
    .field     (trig_cfg[7:4]),
    .legacy_sel(rx_legacy_sel),
    .ext_en    (ext_trig_en),
    .level     (rx_level)
  );

  fti_rx_timeout #(.CW(CW)) u_timeout (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rx_count  (rx_count),
    .idle_pulse(rx_idle_pulse),
    .pop       (rx_pop),
    .timeout   (rx_timeout_irq)
  );

  assign tx_space     = DEPTH_C - tx_count;
  assign rx_avail     = rx_count;
  assign tx_ready_irq = (tx_space >= tx_level);
  assign rx_ready_irq = (rx_count >= rx_level);
endmodule

// File: rtl/fifo_trig_irq_chk.sv
module fifo_trig_irq_chk #(
  parameter int CW = 7,
  parameter int DEPTH = 64
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic [7:0]    trig_cfg,
  input logic [1:0]    tx_legacy_sel,
  input logic [1:0]    rx_legacy_sel,
  input logic          ext_trig_en,
  input logic          rx_idle_pulse,
  input logic          rx_pop,
  input logic          tx_ready_irq,
  input logic          rx_ready_irq,
  input logic          rx_timeout_irq,
  input logic [CW-1:0] tx_space
);
  // R11: free space plus occupancy always equals the depth
  p_space_sum_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(tx_space) + int'(tx_count)) == DEPTH);

  // R10: empty receive FIFO clears the timeout
  p_empty_clears_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_count == '0) |=> !rx_timeout_irq);

  // R10: a read clears the timeout, even alongside an idle pulse
  p_pop_clears_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_pop |=> !rx_timeout_irq);

  // R8: idle with data pending sets the timeout
  p_idle_sets_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_idle_pulse && !rx_pop && (rx_count != '0)) |=> rx_timeout_irq);

  // R9: the flag can only rise after an idle pulse
  p_rise_needs_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rx_timeout_irq) |-> $past(rx_idle_pulse));

  // R5: legacy code 3 on transmit with enable off gives 56
  p_tx_legacy_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ext_trig_en && tx_legacy_sel == 2'd3) |-> (tx_ready_irq == (tx_space >= CW'(56))));

  // R7: full receive FIFO is always at or above any threshold
  p_rx_full_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_count == CW'(DEPTH)) |-> rx_ready_irq);

  // R1: field value 15 gives a transmit threshold of 60
  p_tx_field_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ext_trig_en && trig_cfg[3:0] == 4'hF) |-> (tx_ready_irq == (tx_space >= CW'(60))));

  // R4: legacy receive code 0 gives 8
  p_rx_legacy_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ext_trig_en && rx_legacy_sel == 2'd0) |-> (rx_ready_irq == (rx_count >= CW'(8))));
endmodule

bind fifo_trig_irq fifo_trig_irq_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .tx_count      (tx_count),
  .rx_count      (rx_count),
  .trig_cfg      (trig_cfg),
  .tx_legacy_sel (tx_legacy_sel),
  .rx_legacy_sel (rx_legacy_sel),
  .ext_trig_en   (ext_trig_en),
  .rx_idle_pulse (rx_idle_pulse),
  .rx_pop        (rx_pop),
  .tx_ready_irq  (tx_ready_irq),
  .rx_ready_irq  (rx_ready_irq),
  .rx_timeout_irq(rx_timeout_irq),
  .tx_space      (tx_space)
);

// File: tb/fifo_trig_irq_tb.sv
module fifo_trig_irq_tb;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] tx_count, rx_count;
  logic [7:0]    trig_cfg;
  logic [1:0]    tx_legacy_sel, rx_legacy_sel;
  logic          ext_trig_en, rx_idle_pulse, rx_pop;
  logic          tx_ready_irq, rx_ready_irq, rx_timeout_irq;
  logic [CW-1:0] tx_space, rx_avail;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit exp_to   = 1'b0;
  string ready_tag = "R6";

  always #5 clk = ~clk;

  fifo_trig_irq u_dut (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
    .trig_cfg(trig_cfg), .tx_legacy_sel(tx_legacy_sel), .rx_legacy_sel(rx_legacy_sel),
    .ext_trig_en(ext_trig_en), .rx_idle_pulse(rx_idle_pulse), .rx_pop(rx_pop),
    .tx_ready_irq(tx_ready_irq), .rx_ready_irq(rx_ready_irq),
    .rx_timeout_irq(rx_timeout_irq), .tx_space(tx_space), .rx_avail(rx_avail)
  );

  function automatic int tx_thr(int cfg, int sel, bit en);
    int f = cfg % 16;
    int tab[4] = '{8, 16, 32, 56};
    if (en && f != 0) return f * 4;
    return tab[sel];
  endfunction

  function automatic int rx_thr(int cfg, int sel, bit en);
    int f = cfg / 16;
    int tab[4] = '{8, 16, 56, 60};
    if (en && f != 0) return f * 4;
    return tab[sel];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // model of the timeout flag, advanced at each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) exp_to <= 1'b0;
    else if (rx_pop || rx_count == 0) exp_to <= 1'b0;
    else if (rx_idle_pulse) exp_to <= 1'b1;
  end

  task automatic compare_all(string to_tag);
    int ts = 64 - int'(tx_count);
    chk("R11", "tx_space", int'(tx_space), ts);
    chk("R11", "rx_avail", int'(rx_avail), int'(rx_count));
    chk(ready_tag, "tx_ready", int'(tx_ready_irq),
        int'(ts >= tx_thr(trig_cfg, tx_legacy_sel, ext_trig_en)));
    chk(ready_tag, "rx_ready", int'(rx_ready_irq),
        int'(int'(rx_count) >= rx_thr(trig_cfg, rx_legacy_sel, ext_trig_en)));
    chk(to_tag, "rx_timeout", int'(rx_timeout_irq), int'(exp_to));
  endtask

  // one cycle: check current state at the falling edge, then apply new inputs
  task automatic cyc(string to_tag, int txc, int rxc, bit idle, bit pop);
    @(negedge clk);
    compare_all(to_tag);
    tx_count = CW'(txc); rx_count = CW'(rxc);
    rx_idle_pulse = idle; rx_pop = pop;
  endtask

  initial begin
    rst_n = 1'b0;
    tx_count = '0; rx_count = '0; trig_cfg = '0;
    tx_legacy_sel = '0; rx_legacy_sel = '0; ext_trig_en = 1'b0;
    rx_idle_pulse = 1'b0; rx_pop = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12", "timeout in reset", int'(rx_timeout_irq), 0);
    rst_n = 1'b1;
    repeat (4) cyc("R12", 0, 0, 0, 0);

    // R11 extremes
    cyc("R11", 64, 64, 0, 0);
    cyc("R11", 0, 0, 0, 0);

    // threshold sweep: every field, every legacy code, enable on and off
    for (int en = 0; en < 2; en++) begin
      for (int f = 0; f < 16; f++) begin
        for (int s = 0; s < 4; s++) begin
          int tl, rl;
          trig_cfg = 8'((f << 4) | f);
          tx_legacy_sel = 2'(s); rx_legacy_sel = 2'(3 - s);
          ext_trig_en = en[0];
          if (en == 0) ready_tag = "R3/R4/R5";
          else if (f == 0) ready_tag = "R5/R3/R4";
          else ready_tag = "R1/R2/R6/R7";
          tl = tx_thr(trig_cfg, s, en[0]);
          rl = rx_thr(trig_cfg, 3 - s, en[0]);
          cyc("R10", 64 - (tl - 1), rl - 1, 0, 0);
          cyc("R10", 64 - tl, rl, 0, 0);
          cyc("R10", 0, 0, 0, 0);
        end
      end
    end
    ready_tag = "R6/R7";

    // R8: idle with data sets, independent of the receive threshold (60 here)
    trig_cfg = 8'hF1; ext_trig_en = 1'b1;
    cyc("R8", 10, 1, 1, 0);
    cyc("R8", 10, 1, 0, 0);
    cyc("R8", 10, 1, 0, 0);
    // R10: read clears
    cyc("R8", 10, 1, 0, 1);
    cyc("R10", 10, 1, 0, 0);
    // R10: clear wins over simultaneous idle
    cyc("R10", 10, 3, 1, 1);
    cyc("R10", 10, 3, 0, 0);
    // R9: idle on empty FIFO ignored
    cyc("R9", 10, 0, 1, 0);
    cyc("R9", 10, 0, 0, 0);
    cyc("R9", 10, 0, 0, 0);
    // R10: draining to empty without a read clears
    cyc("R8", 10, 5, 1, 0);
    cyc("R8", 10, 5, 0, 0);
    cyc("R10", 10, 0, 0, 0);
    cyc("R10", 10, 0, 0, 0);
    cyc("R10", 10, 0, 0, 0);

    // R12: reset mid-flag
    cyc("R8", 10, 4, 1, 0);
    cyc("R8", 10, 4, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12", "timeout after reset", int'(rx_timeout_irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc("R12", 10, 4, 0, 0);
    cyc("R12", 10, 4, 0, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule